// File: doc/BRIEF.md
# Chained-Transfer SPI Master

This block is a programmable SPI master controlled through two write-only registers. A settings word fixes the bus options for the next transfer: clock divisor, transfer length, bit order, clock phase and idle level, chip-select level and mask, a half-duplex 3-wire mode, a read request, an end-of-transaction mark, and a flag that releases every pin. A write to the data word then starts one transfer. The block drives SCK, MOSI and a chip-select vector, each with an output enable, and samples MISO, or MOSI in 3-wire mode.

Several transfers can form one transaction under a single chip-select assertion, for example an 8-bit command followed by a 32-bit payload. Chip select is dropped only when a transfer marked as the last one completes. Received data is returned, with a one-cycle strobe, only for transfers that ask for it.

Top module: `spi_xfer_master`

## Requirements
- R1: After synchronous reset, busy, rd_valid, sck_o and mosi_o are 0, every cs_o line is 1, and sck_oe, mosi_oe and cs_oe are 1. The reset settings word is all zeros.
- R2: The settings word is decoded as follows. Bit 0 is offline, bit 1 is end-of-transaction and bit 2 is the read request. Bit 3 sets the chip-select active level (1 means active high) and bit 4 sets the SCK idle level. Bit 5 is the clock phase, bit 6 selects LSB-first and bit 7 selects 3-wire mode. Bits 15:8 hold the divisor minus 2, bits 20:16 hold the length minus 1, and bits 24+NCS-1:24 hold the chip-select mask.
- R3: A data write while idle starts a transfer, and busy is high for exactly L*D cycles, where L is the length and D is the divisor. While busy, data writes and settings writes are ignored, and so is a settings write made in the same cycle as a data write.
- R4: Each bit lasts D cycles, with D between 2 and 257. For the first floor(D/2) cycles of a bit, SCK sits at (idle level XOR phase), and for the rest of the bit it sits at the opposite level. Between transfers SCK sits at the idle level.
- R5: Transmit data is left-aligned in the 32-bit data word. With MSB-first, the wire carries bit 31 downward. With LSB-first, it carries bit 32-L upward. Each bit is presented from the start of its bit period.
- R6: Input is sampled at the clock edge where SCK enters the second half of a bit. rd_data is right-aligned and zero-extended. With MSB-first the first received bit lands in bit L-1; with LSB-first it lands in bit 0.
- R7: rd_valid pulses for one cycle, together with busy falling, only when the read request was set. Otherwise rd_data keeps its previous value.
- R8: When a transfer starts, the cs_o lines selected by the mask go to the active level and the others go inactive. They stay there across transfers until a transfer with the end mark completes, and are released in the same cycle that busy falls.
- R9: In 3-wire mode with a read request, mosi_oe is 0 for the whole transfer and the input is taken from mosi_i. In every other mode, mosi_oe stays 1 and the input is taken from miso_i.
- R10: When offline is set, sck_oe, mosi_oe and cs_oe are all 0 from the cycle after the settings write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings word write strobe |
| cfg_wdata | input | 32 | Settings word |
| dat_we | input | 1 | Data word write strobe; starts a transfer |
| dat_wdata | input | 32 | Transmit data, left-aligned |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | 32 | Received word, right-aligned |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| mosi_i | input | 1 | Serial data in for 3-wire mode |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select lines |
| cs_oe | output | 1 | Chip-select output enable |

## Verification
The bench uses the default NCS of 4, so masks select single lines, partial groups or every line, and the lines left out of a mask are also checked. The divisor and length are runtime fields, so the settings it writes cover D = 2, 3, 4, 5 and 257, odd divisors with uneven half-bits, and lengths of 1, 5, 8, 12, 16 and 32 bits. Together these reach the shortest possible transfer, the widest clock period, and full-word alignment in both bit orders.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;
  localparam int DIV_W  = 8;
  localparam int MASK_W = 8;

  typedef struct packed {
    logic [MASK_W-1:0] cs_mask;
    logic [2:0]        rsv;
    logic [LEN_W-1:0]  len_m1;
    logic [DIV_W-1:0]  div_m2;
    logic              half_duplex;
    logic              lsb_first;
    logic              ck_pha;
    logic              ck_pol;
    logic              cs_pol;
    logic              rd_en;
    logic              last;
    logic              offline;
  } spim_cfg_t;
endpackage

// File: rtl/spim_cfg_reg.sv
module spim_cfg_reg
  import spim_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                lock,
  output spim_cfg_t           cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (wr_en && !lock) cfg_q <= spim_cfg_t'(wr_data);
  end

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(cfg_q));
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m2,
  output logic             smp,
  output logic             bend
);
  localparam int CW = DIV_W + 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic [CW-1:0] half;

  assign period = {1'b0, div_m2} + CW'(2);
  assign half   = period >> 1;
  assign smp    = run && ((cnt + 1'b1) == half);
  assign bend   = run && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= '0;
    else if (run) cnt <= bend ? '0 : cnt + 1'b1;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < period));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W     = 32,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [W-1:0]     load_word,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             lsb_first,
  input  logic             smp,
  input  logic             shift,
  input  logic             clear,
  input  logic             din,
  output logic             dout,
  output logic             last_bit,
  output logic [W-1:0]     rx_word
);
  logic [W-1:0]     tx;
  logic [W-1:0]     rx;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] sh_amt;

  assign sh_amt   = LEN_W'(W - 1) - len_m1;
  assign dout     = lsb_first ? tx[0] : tx[W-1];
  assign last_bit = (idx == len_m1);
  assign rx_word  = lsb_first ? (rx >> sh_amt) : rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx  <= '0;
      rx  <= '0;
      idx <= '0;
    end else if (start) begin
      tx  <= lsb_first ? (load_word >> sh_amt) : load_word;
      rx  <= '0;
      idx <= '0;
    end else begin
      if (clear) tx <= '0;
      else if (shift) begin
        tx  <= lsb_first ? (tx >> 1) : (tx << 1);
        idx <= idx + 1'b1;
      end
      if (smp) rx <= lsb_first ? {din, rx[W-1:1]} : {rx[W-2:0], din};
    end
  end

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (idx <= len_m1));
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spim_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              dat_we,
  input  logic [31:0]       dat_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic [NCS-1:0]    cs_o,
  output logic              cs_oe
);
  spim_cfg_t          cfg_q;
  logic               start;
  logic               fin;
  logic               smp;
  logic               bend;
  logic               last_bit;
  logic               din;
  logic [WORD_W-1:0]  rx_word;
  logic [NCS-1:0]     cs_act;
  logic               lead_lvl;
  logic               unused_cfg;

  assign unused_cfg = ^{cfg_q.rsv, cfg_q.cs_mask};
  assign start    = dat_we && !busy;
  assign fin      = bend && last_bit;
  assign din      = cfg_q.half_duplex ? mosi_i : miso_i;
  assign lead_lvl = cfg_q.ck_pol ^ cfg_q.ck_pha;

  spim_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .lock(busy || dat_we), .cfg_q(cfg_q)
  );

  spim_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .start(start), .run(busy),
    .div_m2(cfg_q.div_m2), .smp(smp), .bend(bend)
  );

  spim_shifter #(.W(WORD_W), .LEN_W(LEN_W)) u_sh (
    .clk(clk), .rst(rst), .start(start), .run(busy), .load_word(dat_wdata),
    .len_m1(cfg_q.len_m1), .lsb_first(cfg_q.lsb_first), .smp(smp),
    .shift(bend && !last_bit), .clear(fin), .din(din),
    .dout(mosi_o), .last_bit(last_bit), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cs_act   <= '0;
      sck_o    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cs_act <= cfg_q.cs_mask[NCS-1:0];
        sck_o  <= lead_lvl;
      end else if (busy) begin
        if (fin) begin
          busy  <= 1'b0;
          sck_o <= cfg_q.ck_pol;
          if (cfg_q.last) cs_act <= '0;
          if (cfg_q.rd_en) begin
            rd_valid <= 1'b1;
            rd_data  <= rx_word;
          end
        end else if (smp) sck_o <= ~lead_lvl;
        else if (bend) sck_o <= lead_lvl;
      end else begin
        sck_o <= cfg_q.ck_pol;
      end
    end
  end

  assign cs_o    = cs_act ^ {NCS{~cfg_q.cs_pol}};
  assign cs_oe   = !cfg_q.offline;
  assign sck_oe  = !cfg_q.offline;
  assign mosi_oe = !cfg_q.offline && !(busy && cfg_q.half_duplex && cfg_q.rd_en);

  // R7
  rdv_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!busy && $past(busy)));
  // R8
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cs_act));
  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(cfg_q.last)) |-> (cs_act == '0));
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sck_o == $past(cfg_q.ck_pol)));
endmodule

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;
  localparam int NCS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_we, dat_we, mosi_i, miso_i;
  logic [31:0] cfg_wdata, dat_wdata, rd_data;
  logic busy, rd_valid, sck_o, sck_oe, mosi_o, mosi_oe, cs_oe;
  logic [NCS-1:0] cs_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [NCS-1:0] exp_act = '0;
  logic [31:0] last_rd = '0;

  spi_xfer_master #(.NCS(NCS)) u_spi_xfer_master (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_i(miso_i), .cs_o(cs_o), .cs_oe(cs_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit off, input bit lst, input bit rd, input bit csp,
      input bit ckp, input bit pha, input bit lsb, input bit hd, input int dm2, input int len,
      input logic [7:0] mask);
    logic [31:0] c;
    c = '0;
    c[0] = off; c[1] = lst; c[2] = rd; c[3] = csp;
    c[4] = ckp; c[5] = pha; c[6] = lsb; c[7] = hd;
    c[15:8] = dm2[7:0];
    c[20:16] = 5'(len - 1);
    c[31:24] = mask;
    return c;
  endfunction

  function automatic bit sbit(input logic [31:0] s, input int len, input bit lsb, input int i);
    if (i >= len) return 1'b0;
    return lsb ? s[i] : s[len-1-i];
  endfunction

  task automatic set_in(input bit b, input bit hd);
    if (hd) begin mosi_i = b; miso_i = ~b; end
    else begin miso_i = b; mosi_i = ~b; end
  endtask

  task automatic xfer(input logic [31:0] c, input logic [31:0] d, input logic [31:0] s, input bit poke);
    int len, dv, cnt, bi, mism;
    bit pol, pha, lsb, hd, rd, lst, csp, prev, cs_bad, oe_bad, lead_bad;
    logic [NCS-1:0] msk;
    logic [31:0] cap, expw;
    logic [63:0] lm;
    len = int'(c[20:16]) + 1; dv = int'(c[15:8]) + 2;
    lst = c[1]; rd = c[2]; csp = c[3]; pol = c[4]; pha = c[5]; lsb = c[6]; hd = c[7];
    msk = c[24 +: NCS];
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk); cfg_we = 1'b0;
    bi = 0; set_in(sbit(s, len, lsb, 0), hd);
    dat_we = 1'b1; dat_wdata = d;
    @(negedge clk); dat_we = 1'b0;
    exp_act = msk;
    cnt = 0; prev = pol; cap = '0; cs_bad = 0; oe_bad = 0; lead_bad = 0;
    while (busy === 1'b1 && cnt < 5000) begin
      cnt++;
      if (cnt == 1 && sck_o !== (pol ^ pha)) lead_bad = 1;
      if (cs_o !== (exp_act ^ {NCS{~csp}})) cs_bad = 1;
      if ((hd && rd) ? (mosi_oe !== 1'b0) : (mosi_oe !== 1'b1)) oe_bad = 1;
      if (sck_o !== prev && sck_o === ~(pol ^ pha)) begin
        if (bi < 32) cap[bi] = mosi_o;
        bi++;
        set_in(sbit(s, len, lsb, bi), hd);
      end
      if (poke && cnt == 3) begin
        cfg_we = 1'b1; cfg_wdata = c ^ 32'h10; dat_we = 1'b1; dat_wdata = ~d;
      end
      if (poke && cnt == 4) begin cfg_we = 1'b0; dat_we = 1'b0; end
      prev = sck_o;
      @(negedge clk);
    end
    chk(cnt == len * dv, "R3 busy length", 64'(cnt), 64'(len * dv));
    chk(!lead_bad, "R4 first half-bit SCK level", 64'(lead_bad), 0);
    chk(bi == len, "R4 sample edges per transfer", 64'(bi), 64'(len));
    if (!(hd && rd)) begin
      mism = 0; expw = '0;
      for (int i = 0; i < len; i++) begin
        expw[i] = lsb ? d[32-len+i] : d[31-i];
        if (cap[i] !== expw[i]) mism++;
      end
      chk(mism == 0, "R5 MOSI bit stream", 64'(cap), 64'(expw));
    end
    chk(oe_bad == 0, "R9 mosi_oe during transfer", 64'(oe_bad), 0);
    chk(cs_bad == 0, "R8 chip select during transfer", 64'(cs_bad), 0);
    chk(rd_valid === rd, "R7 rd_valid at end", 64'(rd_valid), 64'(rd));
    lm = (64'd1 << len) - 1;
    if (rd) begin
      chk(rd_data === (s & lm[31:0]), "R6 received word", 64'(rd_data), 64'(s & lm[31:0]));
      last_rd = s & lm[31:0];
    end else begin
      chk(rd_data === last_rd, "R7 rd_data held", 64'(rd_data), 64'(last_rd));
    end
    if (lst) exp_act = '0;
    chk(cs_o === (exp_act ^ {NCS{~csp}}), "R8 chip select after transfer",
        64'(cs_o), 64'(exp_act ^ {NCS{~csp}}));
    @(negedge clk);
    chk(rd_valid === 1'b0, "R7 single-cycle strobe", 64'(rd_valid), 0);
    @(negedge clk);
    chk(sck_o === pol, "R3 R4 SCK idle level (writes while busy ignored)", 64'(sck_o), 64'(pol));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    rst = 1'b1; cfg_we = 0; dat_we = 0; cfg_wdata = '0; dat_wdata = '0; mosi_i = 0; miso_i = 0;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", 64'(busy), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid", 64'(rd_valid), 0);
    chk(cs_o === {NCS{1'b1}}, "R1 cs_o", 64'(cs_o), 64'({NCS{1'b1}}));
    chk(sck_o === 1'b0 && mosi_o === 1'b0, "R1 sck_o/mosi_o", 64'({sck_o, mosi_o}), 0);
    chk({sck_oe, mosi_oe, cs_oe} === 3'b111, "R1 enables", 64'({sck_oe, mosi_oe, cs_oe}), 7);

    // R8 chained transaction: command then payload under one chip select
    xfer(mk_cfg(0,0,0,0,0,0,0,0, 3, 8, 8'h06), 32'h1300_0000, 32'h0, 0);
    repeat (3) @(negedge clk);
    chk(cs_o === 4'b1001, "R8 chip select held between transfers", 64'(cs_o), 64'h9);
    xfer(mk_cfg(0,1,1,0,0,0,0,0, 3, 32, 8'h06), 32'hDEAD_BEEF, 32'h5A5A_C3C3, 0);
    // R4 R8 active-high CS, idle-high SCK, phase 1, odd divisor 3
    xfer(mk_cfg(0,1,1,1,1,1,0,0, 1, 12, 8'h09), 32'hABC0_0000, 32'h0000_09A5, 0);
    // R5 R6 LSB-first, 5 bits
    xfer(mk_cfg(0,1,1,0,0,1,1,0, 0, 5, 8'h01), 32'hA800_0000, 32'h0000_0016, 0);
    // R4 largest divisor 257
    xfer(mk_cfg(0,1,1,0,1,0,0,0, 255, 2, 8'h02), 32'h8000_0000, 32'h0000_0001, 0);
    // R9 3-wire read and write
    xfer(mk_cfg(0,1,1,0,0,0,0,1, 2, 16, 8'h04), 32'h0, 32'h0000_BEEF, 0);
    xfer(mk_cfg(0,1,0,0,0,0,0,1, 2, 16, 8'h04), 32'h1234_0000, 32'h0, 0);
    // R3 writes while busy are ignored
    xfer(mk_cfg(0,1,0,0,0,0,0,0, 2, 8, 8'h03), 32'hC500_0000, 32'h0, 1);
    // R3 shortest transfer: 1 bit, divisor 2
    xfer(mk_cfg(0,1,1,0,0,0,0,0, 0, 1, 8'h01), 32'h8000_0000, 32'h0000_0001, 0);

    // R10 offline releases every pin
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk_cfg(1,1,0,0,0,0,0,0, 0, 8, 8'h01);
    @(negedge clk); cfg_we = 1'b0;
    chk({sck_oe, mosi_oe, cs_oe} === 3'b000, "R10 offline enables", 64'({sck_oe, mosi_oe, cs_oe}), 0);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk_cfg(0,1,0,0,0,0,0,0, 0, 8, 8'h01);
    @(negedge clk); cfg_we = 1'b0;
    chk({sck_oe, mosi_oe, cs_oe} === 3'b111, "R10 back online", 64'({sck_oe, mosi_oe, cs_oe}), 7);

    // R2 R5 R6 R8 random settings
    for (int k = 0; k < 24; k++) begin
      c = mk_cfg(0, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 2, $urandom % 2, int'($urandom % 5),
                 int'($urandom % 32) + 1, 8'(($urandom % 15) + 1));
      xfer(c, $urandom, $urandom, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule